// File: doc/BRIEF.md
# Windowed data address translator

This block maps a logical data address onto a physical location in one of three memory spaces: unified memory, instruction memory or on-chip data memory. The 64 KB logical space is cut into four 16 KB windows. Each window has its own 16-bit map register. Windows 0 to 2 read a space code and a segment number from their register. Window 3 is a fixed I/O window that always lands in on-chip data memory. It is split into four 4 KB sub-windows, and each sub-window is paged by its own nibble of the window 3 register.

Translation is combinational. A requester presents a logical address and the byte count it wants to move. The block returns:
- the physical address;
- a space tag;
- a fault flag;
- the number of bytes that can be moved without leaving the current window.

The map registers sit in the data address space and are written through a simple write port. The write takes effect on the next clock edge. One extra address is a shadow alias of register 2. The memories themselves are outside this block.

Top module: `dxl_translator`

## Requirements
- R1: While reset is asserted, and from then on until a register is written, map registers 0 to 3 hold 0x2000, 0x2000, 0x2000 and 0x0000. With these values, windows 0 to 2 map one-to-one onto on-chip data memory and window 3 lands at physical 0xC000 plus the offset.
- R2: In windows 0 to 2 the space code is map bits [13:12] and the segment is map bits [9:0]. Code 00 gives `space`=0 (unified) and phys = segment × 0x4000 + offset, where offset is logical bits [13:0].
- R3: Space code 01 gives `space`=1 (instruction) and phys = segment × 0x4000 + offset.
- R4: Space code 10 gives `space`=2 (on-chip data) and phys = segment × 0x10000 + window × 0x4000 + offset, where window is logical bits [15:14].
- R5: Space code 11 is reserved. It raises `fault`, with `phys_addr`=0, `space`=3 and `xfer_len`=0.
- R6: Window 3 never faults and always gives `space`=2. The sub-window index k is offset bits [13:12]. The page is map bits [15−4k : 12−4k], and phys = page × 0x10000 + 0xC000 + offset.
- R7: When the window does not fault, `xfer_len` = min(`req_len`, 0x4000 − offset). A request of length 0 gives 0 with no fault.
- R8: A logical address of 0x10000 or above raises `fault`, with `xfer_len`=0, `phys_addr`=0 and `space`=3.
- R9: A write with `map_wr_en` high to address 0xFF08 + 2n loads `map_wr_data` into map register n (n = 0 to 3). The new value is used from the next clock edge on.
- R10: A write to 0xFF04 loads map register 2, exactly as a write to 0xFF0C does.
- R11: A write to any other address, including odd addresses inside the register range, leaves all four map registers unchanged.
- R12: In windows 0 to 2, map bits [15:14] and [11:10] have no effect on the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the map register reset values |
| map_wr_en | input | 1 | Map register write strobe |
| map_wr_addr | input | 16 | Data address of the write |
| map_wr_data | input | 16 | Value to write |
| laddr | input | 18 | Logical address; values of 0x10000 and above are out of range |
| req_len | input | 15 | Requested transfer length in bytes |
| phys_addr | output | 26 | Physical address (0 on fault) |
| space | output | 2 | 0 unified, 1 instruction, 2 on-chip data, 3 none (fault) |
| fault | output | 1 | Translation fault |
| xfer_len | output | 15 | Bytes that can be moved without leaving the window |

## Verification
The hardest situations to reach are the ones that depend on stored map state: a reserved space code, a register loaded through the alias address, and the four window 3 sub-windows each reading a different nibble. None of these can be seen from reset, so each stimulus step can write a map register and translate in the same cycle; the result is sampled after the edge, where the new map value applies. Ignored writes are followed at once by translations through the register they might have corrupted. Clipping is driven at both the last byte of a window and exactly at the boundary.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  // Space tag; codes 0..2 match the map register space field.
  typedef enum logic [1:0] {
    SPC_UNIFIED = 2'b00,
    SPC_INSN    = 2'b01,
    SPC_DATA    = 2'b10,
    SPC_NONE    = 2'b11
  } spc_e;
endpackage

// File: rtl/dxl_map_regs.sv
module dxl_map_regs #(
  parameter int NUM_MAP    = 4,
  parameter int MAP_W      = 16,
  parameter int ADDR_W     = 16,
  parameter int MAP_BASE   = 'hFF08,
  parameter int ALIAS_ADDR = 'hFF04,
  parameter int ALIAS_IDX  = 2,
  parameter logic [NUM_MAP*MAP_W-1:0] RST_VALS = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [MAP_W-1:0]                  wr_data,
  output logic [NUM_MAP-1:0][MAP_W-1:0]     map_q
);
  localparam logic [ADDR_W-1:0] ALIAS_A = ADDR_W'(ALIAS_ADDR);

  logic [NUM_MAP-1:0] hit;          // per-register write select
  logic               hit_any;
  logic [MAP_W-1:0]   regs_q [NUM_MAP];

  for (genvar n = 0; n < NUM_MAP; n++) begin : g_reg
    localparam logic [ADDR_W-1:0] HOME = ADDR_W'(MAP_BASE + 2 * n);
    localparam bit HAS_ALIAS = (n == ALIAS_IDX);

    assign hit[n] = wr_en && ((wr_addr == HOME) || (HAS_ALIAS && (wr_addr == ALIAS_A)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[n] <= RST_VALS[n*MAP_W +: MAP_W];
      else if (hit[n]) regs_q[n] <= wr_data;
    end

    assign map_q[n] = regs_q[n];

    // R9: a write at the home address lands on the next edge
    a_r9_home_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == HOME)) |=> (map_q[n] == $past(wr_data)))
      else $error("a_r9_home_write reg %0d", n);
  end

  assign hit_any = |hit;

  // R10: the shadow address loads the aliased register
  a_r10_alias_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == ALIAS_A)) |=> (map_q[ALIAS_IDX] == $past(wr_data)))
    else $error("a_r10_alias_write");

  // R11: without a decoded write nothing changes
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |=> $stable(map_q))
    else $error("a_r11_hold");

  // R11: at most one register is selected by any address
  a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit))
    else $error("a_r11_one_target");

  // R1: reset leaves the documented values
  a_r1_reset_vals: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (map_q == RST_VALS))
    else $error("a_r1_reset_vals");
endmodule

// File: rtl/dxl_win_map.sv
module dxl_win_map #(
  parameter int OFF_W   = 14,
  parameter int WIN_W   = 2,
  parameter int SEG_W   = 10,
  parameter int PA_W    = 26,
  parameter int MAP_W   = 16,
  parameter int SPC_LSB = 12,
  parameter int WIN_IDX = 0
) (
  input  logic [MAP_W-1:0] map_word,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  phys,
  output dxl_pkg::spc_e    spc,
  output logic             bad
);
  import dxl_pkg::*;

  // Segment-scaled placement used by unified and instruction space.
  function automatic logic [PA_W-1:0] f_flat(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o);
    return (PA_W'(s) << OFF_W) + PA_W'(o);
  endfunction

  // On-chip data placement keeps the window position inside a 64 KB page.
  function automatic logic [PA_W-1:0] f_paged(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o);
    return (PA_W'(s) << (OFF_W + WIN_W)) + PA_W'(WIN_IDX << OFF_W) + PA_W'(o);
  endfunction

  logic [SEG_W-1:0] seg;
  logic [1:0]       code;
  logic             unused_map_bits;

  assign seg  = map_word[SEG_W-1:0];
  assign code = map_word[SPC_LSB +: 2];
  assign unused_map_bits = ^{map_word[MAP_W-1:SPC_LSB+2], map_word[SPC_LSB-1:SEG_W]};

  always_comb begin
    phys = '0;
    spc  = SPC_NONE;
    bad  = 1'b0;
    case (code)
      2'b00: begin phys = f_flat(seg, off);  spc = SPC_UNIFIED; end
      2'b01: begin phys = f_flat(seg, off);  spc = SPC_INSN;    end
      2'b10: begin phys = f_paged(seg, off); spc = SPC_DATA;    end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/dxl_io_map.sv
module dxl_io_map #(
  parameter int OFF_W   = 14,
  parameter int WIN_W   = 2,
  parameter int PA_W    = 26,
  parameter int MAP_W   = 16,
  parameter int PAGE_W  = 4,
  parameter int SUB_W   = 2,
  parameter int IO_BASE = 'hC000
) (
  input  logic [MAP_W-1:0] map_word,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  phys
);
  localparam int NSUB = 1 << SUB_W;

  // Sub-window 0 uses the most significant nibble.
  function automatic logic [PAGE_W-1:0] f_page(input logic [MAP_W-1:0] m, input logic [SUB_W-1:0] s);
    logic [PAGE_W-1:0] pg;
    pg = '0;
    for (int k = 0; k < NSUB; k++)
      if (s == SUB_W'(k)) pg = m[MAP_W - PAGE_W*(k+1) +: PAGE_W];
    return pg;
  endfunction

  logic [SUB_W-1:0]  sub;
  logic [PAGE_W-1:0] page;

  assign sub  = off[OFF_W-1 -: SUB_W];
  assign page = f_page(map_word, sub);
  assign phys = (PA_W'(page) << (OFF_W + WIN_W)) + PA_W'(IO_BASE) + PA_W'(off);
endmodule

// File: rtl/dxl_len_clip.sv
module dxl_len_clip #(
  parameter int OFF_W = 14
) (
  input  logic [OFF_W-1:0] off,
  input  logic [OFF_W:0]   req,
  input  logic             kill,
  output logic [OFF_W:0]   len
);
  localparam int LEN_W     = OFF_W + 1;
  localparam int WIN_BYTES = 1 << OFF_W;

  function automatic logic [LEN_W-1:0] f_clip(input logic [OFF_W-1:0] o, input logic [LEN_W-1:0] r);
    logic [LEN_W-1:0] room;
    room = LEN_W'(WIN_BYTES) - LEN_W'(o);
    return (r > room) ? room : r;
  endfunction

  assign len = kill ? '0 : f_clip(off, req);
endmodule

// File: rtl/dxl_translator.sv
module dxl_translator #(
  parameter int LADDR_W    = 18,
  parameter int DADDR_W    = 16,
  parameter int OFF_W      = 14,
  parameter int SEG_W      = 10,
  parameter int PA_W       = 26,
  parameter int MAP_BASE   = 'hFF08,
  parameter int ALIAS_ADDR = 'hFF04,
  parameter int ALIAS_IDX  = 2,
  parameter logic [63:0] MAP_RST = 64'h0000_2000_2000_2000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_wr_en,
  input  logic [DADDR_W-1:0] map_wr_addr,
  input  logic [DADDR_W-1:0] map_wr_data,
  input  logic [LADDR_W-1:0] laddr,
  input  logic [OFF_W:0]     req_len,
  output logic [PA_W-1:0]    phys_addr,
  output logic [1:0]         space,
  output logic               fault,
  output logic [OFF_W:0]     xfer_len
);
  import dxl_pkg::*;

  localparam int WIN_W     = DADDR_W - OFF_W;
  localparam int NUM_WIN   = 1 << WIN_W;
  localparam int MAP_W     = DADDR_W;
  localparam int WIN_BYTES = 1 << OFF_W;

  logic [NUM_WIN-1:0][MAP_W-1:0] map_q;
  logic [WIN_W-1:0]              win;
  logic [OFF_W-1:0]              off;
  logic                          out_rng;
  logic [NUM_WIN-1:0][PA_W-1:0]  w_phys;
  spc_e                          w_spc [NUM_WIN];
  logic [NUM_WIN-1:0]            w_bad;

  assign win     = laddr[OFF_W +: WIN_W];
  assign off     = laddr[OFF_W-1:0];
  assign out_rng = |laddr[LADDR_W-1:DADDR_W];

  dxl_map_regs #(
    .NUM_MAP(NUM_WIN), .MAP_W(MAP_W), .ADDR_W(DADDR_W),
    .MAP_BASE(MAP_BASE), .ALIAS_ADDR(ALIAS_ADDR), .ALIAS_IDX(ALIAS_IDX),
    .RST_VALS(MAP_RST[NUM_WIN*MAP_W-1:0])
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(map_wr_en), .wr_addr(map_wr_addr),
    .wr_data(map_wr_data), .map_q(map_q)
  );

  // Ordinary windows decode space and segment; the last one is the I/O window.
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    if (w < NUM_WIN - 1) begin : g_std
      dxl_win_map #(
        .OFF_W(OFF_W), .WIN_W(WIN_W), .SEG_W(SEG_W), .PA_W(PA_W),
        .MAP_W(MAP_W), .WIN_IDX(w)
      ) u_map (
        .map_word(map_q[w]), .off(off), .phys(w_phys[w]), .spc(w_spc[w]), .bad(w_bad[w])
      );
    end else begin : g_io
      dxl_io_map #(
        .OFF_W(OFF_W), .WIN_W(WIN_W), .PA_W(PA_W), .MAP_W(MAP_W)
      ) u_io (
        .map_word(map_q[w]), .off(off), .phys(w_phys[w])
      );
      assign w_spc[w] = SPC_DATA;
      assign w_bad[w] = 1'b0;
    end
  end

  assign fault     = out_rng | w_bad[win];
  assign phys_addr = fault ? '0 : w_phys[win];
  assign space     = fault ? SPC_NONE : w_spc[win];

  dxl_len_clip #(.OFF_W(OFF_W)) u_clip (
    .off(off), .req(req_len), .kill(fault), .len(xfer_len)
  );

  // R5: a fault carries no address, no space and no bytes
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (xfer_len == '0 && phys_addr == '0 && space == SPC_NONE))
    else $error("a_r5_fault_zero");

  // R7: a granted transfer stays inside the window
  a_r7_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> ((32'(off) + 32'(xfer_len)) <= 32'(WIN_BYTES)))
    else $error("a_r7_no_cross");

  // R7: never more than requested
  a_r7_within_req: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_len <= req_len)
    else $error("a_r7_within_req");

  // R8: addresses past the last window fault
  a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_rng |-> fault)
    else $error("a_r8_range");

  // R6: the I/O window always resolves to on-chip data
  a_r6_io_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_rng && win == WIN_W'(NUM_WIN - 1)) |-> (!fault && space == SPC_DATA))
    else $error("a_r6_io_data");
endmodule

// File: tb/dxl_translator_bench.sv
module dxl_translator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_wr_en = 1'b0;
  logic [15:0] map_wr_addr = '0;
  logic [15:0] map_wr_data = '0;
  logic [17:0] laddr = '0;
  logic [14:0] req_len = '0;
  logic [25:0] phys_addr;
  logic [1:0]  space;
  logic        fault;
  logic [14:0] xfer_len;

  int n_vec = 0;
  int n_bad = 0;
  int mdl [4];

  always #5 clk = ~clk;

  dxl_translator u_dxl_translator (
    .clk(clk), .rst_n(rst_n), .map_wr_en(map_wr_en), .map_wr_addr(map_wr_addr),
    .map_wr_data(map_wr_data), .laddr(laddr), .req_len(req_len),
    .phys_addr(phys_addr), .space(space), .fault(fault), .xfer_len(xfer_len)
  );

  // Stimulus table: write address (0 = no write), write data, logical address, length, tag.
  localparam int NV = 20;
  localparam logic [15:0] V_WA [NV] = '{
    16'h0000, 16'h0000, 16'h0000, 16'h0000,   // R1 reset map
    16'hFF08, 16'hFF0A, 16'hFF0C, 16'hFF0E,   // R2 R3 R4 R6
    16'h0000, 16'h0000, 16'h0000,             // R6 sub-windows, R7 clip
    16'hFF04, 16'hFF08,                       // R10 alias, R5 reserved
    16'hFF06, 16'hFF10, 16'hFF09,             // R11 ignored writes
    16'h0000, 16'h0000,                       // R8 out of range
    16'hFF08, 16'hFF08 };                     // R12 ignored map bits
  localparam logic [15:0] V_WD [NV] = '{
    16'h0, 16'h0, 16'h0, 16'h0,
    16'h0005, 16'h1003, 16'h23FF, 16'h1234,
    16'h0, 16'h0, 16'h0,
    16'h1007, 16'h3000,
    16'hFFFF, 16'hFFFF, 16'hFFFF,
    16'h0, 16'h0,
    16'hC00A, 16'h0C05 };
  localparam int V_LA [NV] = '{
    'h00010, 'h04010, 'h08000, 'h0C123,
    'h00100, 'h04200, 'h0BFFE, 'h0C000,
    'h0D005, 'h0E00F, 'h0FFFF,
    'h08020, 'h00000,
    'h00000, 'h0C000, 'h04000,
    'h10000, 'h3FFFF,
    'h03FFF, 'h00001 };
  localparam int V_LN [NV] = '{
    4, 2, 8, 1,
    4, 16, 8, 4,
    2, 3, 4,
    4, 4,
    4, 4, 4,
    4, 4,
    0, 1 };
  localparam int V_REQ [NV] = '{
    1, 1, 1, 1,
    2, 3, 4, 6,
    6, 6, 7,
    10, 5,
    11, 11, 11,
    8, 8,
    12, 12 };

  // Reference model of the stored map registers.
  task automatic mdl_reset();
    mdl[0] = 'h2000; mdl[1] = 'h2000; mdl[2] = 'h2000; mdl[3] = 'h0000;
  endtask

  task automatic mdl_write(input int wa, input int wd);
    for (int n = 0; n < 4; n++)
      if (wa == 'hFF08 + 2 * n) mdl[n] = wd;
    if (wa == 'hFF04) mdl[2] = wd;
  endtask

  task automatic mdl_xlat(input int la, input int rq,
                          output longint ph, output int sp, output int ft, output int ln);
    int w, o, m, sub, pg;
    ft = 0; ph = 0; sp = 3; ln = 0;
    if (la >= 'h10000) ft = 1;
    else begin
      w = la / 'h4000;
      o = la % 'h4000;
      m = mdl[w];
      if (w == 3) begin
        sub = o / 'h1000;
        pg  = (m >> (12 - 4 * sub)) & 'hF;
        ph  = longint'(pg) * 'h10000 + 'hC000 + o;
        sp  = 2;
      end else begin
        case ((m >> 12) & 3)
          0: begin ph = longint'(m & 'h3FF) * 'h4000 + o; sp = 0; end
          1: begin ph = longint'(m & 'h3FF) * 'h4000 + o; sp = 1; end
          2: begin ph = longint'(m & 'h3FF) * 'h10000 + w * 'h4000 + o; sp = 2; end
          default: ft = 1;
        endcase
      end
      if (ft == 0) ln = (o + rq > 'h4000) ? ('h4000 - o) : rq;
    end
    if (ft != 0) begin ph = 0; sp = 3; ln = 0; end
  endtask

  // Drive at the falling edge, let the write land, sample 1 ns after the rising edge.
  task automatic apply(input int wa, input int wd, input int la, input int ln);
    @(negedge clk);
    map_wr_en   = (wa != 0);
    map_wr_addr = 16'(wa);
    map_wr_data = 16'(wd);
    laddr       = 18'(la);
    req_len     = 15'(ln);
    @(posedge clk);
    #1;
    map_wr_en = 1'b0;
  endtask

  task automatic check_out(input string tag, input longint eph, input int esp,
                           input int eft, input int eln);
    n_vec++;
    if (longint'(phys_addr) != eph || int'(space) != esp ||
        int'(fault) != eft || int'(xfer_len) != eln) begin
      n_bad++;
      $display("FAIL %s: got phys=%h space=%0d fault=%0d len=%0d, expected phys=%h space=%0d fault=%0d len=%0d",
               tag, phys_addr, space, fault, xfer_len, eph, esp, eft, eln);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    longint eph;
    int esp, eft, eln;
    mdl_reset();

    // R1: reset values observed while reset is still held
    @(negedge clk);
    laddr = 18'h04010; req_len = 15'd4;
    #1 check_out("R1 during reset", 'h4010, 2, 0, 4);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // Table walk against the reference model
    for (int i = 0; i < NV; i++) begin
      mdl_write(int'(V_WA[i]), int'(V_WD[i]));
      apply(int'(V_WA[i]), int'(V_WD[i]), V_LA[i], V_LN[i]);
      mdl_xlat(V_LA[i], V_LN[i], eph, esp, eft, eln);
      check_out($sformatf("R%0d vector %0d", V_REQ[i], i), eph, esp, eft, eln);
    end

    // Directed: a second reset restores the map (R1)
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    apply(0, 0, 'h00010, 4);
    check_out("R1 window 0 after reset", 'h10, 2, 0, 4);
    apply(0, 0, 'h0C123, 1);
    check_out("R1 window 3 after reset", 'hC123, 2, 0, 1);

    // R7: one byte left at the window end, then a zero-length request
    apply(0, 0, 'h0BFFF, 9);
    check_out("R7 last byte", 'hBFFF, 2, 0, 1);
    apply(0, 0, 'h04000, 0);
    check_out("R7 zero length", 'h4000, 2, 0, 0);

    // R10: alias write to register 2, unified segment 2
    apply('hFF04, 'h0002, 'h08004, 2);
    check_out("R10 alias", 'h8004, 0, 0, 2);

    // R9: home write to register 2 overrides, instruction segment 1
    apply('hFF0C, 'h1001, 'h08004, 2);
    check_out("R9 home write", 'h4004, 1, 0, 2);

    // R5: reserved space with the largest request
    apply('hFF08, 'h3000, 'h00000, 'h7FFF);
    check_out("R5 reserved", 0, 3, 1, 0);

    // R8: far out of range
    apply(0, 0, 'h20000, 4);
    check_out("R8 out of range", 0, 3, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule